// File: doc/BRIEF.md
# Slave Sync Tracker

This block locks a pixel-clock timing base to horizontal and vertical sync strobes supplied by an upstream controller. It samples both active-low syncs once per clock and keeps a horizontal pixel count and a line number. It decides from the relative placement of the vertical and horizontal sync edges whether a field is the first or the second field of a frame. For every pixel it marks whether the multiplexed 4:2:2 byte stream is carrying active video and whether that byte is a blue-difference, luma or red-difference sample. A composite encoder uses these outputs to pick out samples and to place sync, burst and blanking.

Two line standards are built in, and a mode input selects between them. The 525-line standard has 1560 clocks per line. The 625-line standard has 1888 clocks per line. Each sync input passes through its own delay of 0 to 7 clocks before it is examined. When syncs stop arriving or arrive out of place, the counters keep running from the last timing they had, so the encoder keeps producing a stable picture.

Top module: `slave_sync_tracker`

## Requirements
- R1: The first clock edge that samples the (delayed) horizontal sync low after it was high sets `h_count` to 0 at that edge.
- R2: With no horizontal sync fall, `h_count` advances by one per clock and wraps from 1559 (mode 0) or 1887 (mode 1) to 0.
- R3: `active` is 1 for counts 236..1515 in mode 0 and 310..1845 in mode 1, and 0 elsewhere. Inside that window `comp_tag` repeats, counting from the first active count, as 2'b00 (blue difference), 2'b01 (luma), 2'b10 (red difference), 2'b01 (luma). Outside the window `comp_tag` is 2'b11.
- R4: When `swap_cbcr` is 1, the active positions that would carry 2'b00 carry 2'b10 and the reverse. Luma positions are unchanged.
- R5: A vertical sync fall sampled while horizontal sync is sampled low marks the first field. This also holds when both fall on the same clock. `line_num` becomes 4 (mode 0) or 1 (mode 1) and `even_field` becomes 0.
- R6: `line_num` advances by one each time `h_count` returns to 0. It wraps from 525 (mode 0) or 625 (mode 1) to 1.
- R7: A vertical sync fall sampled while horizontal sync is high sets `even_field` only when the new pixel is on line 266 at count 780 or later (mode 0), or on line 313 at count 944 or later (mode 1). Outside that window the fall changes neither `even_field` nor `line_num`.
- R8: Without sync, `even_field` becomes 1 when the count reaches line 267 (mode 0) or 314 (mode 1). It becomes 0 when the count reaches the first-field line, 4 or 1.
- R9: `hs_delay` delays the horizontal sync by 0 to 7 clocks before edge detection.
- R10: `vs_delay` delays the vertical sync by 0 to 7 clocks before edge detection.
- R11: A horizontal sync fall at any count other than the expected one restarts `h_count` at 0 and advances `line_num`.
- R12: `frame_start` is 1 for exactly one cycle, the cycle in which the first-field line number first appears.
- R13: After reset, `h_count` is 0, `line_num` is 1, `even_field` is 0, `active` is 0, `comp_tag` is 2'b11 and `frame_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_mode | input | 1 | 0 selects the 525-line standard, 1 selects the 625-line standard |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| hs_delay | input | 3 | Horizontal sync delay in clocks |
| vs_delay | input | 3 | Vertical sync delay in clocks |
| swap_cbcr | input | 1 | Exchange the positions of the two chroma samples |
| h_count | output | HW | Horizontal pixel count |
| line_num | output | LW | Line number within the frame |
| even_field | output | 1 | 1 during the second field |
| active | output | 1 | Pixel lies in the active byte window |
| comp_tag | output | 2 | Sample kind of the current byte |
| frame_start | output | 1 | One-cycle pulse at the start of the first field |

## Verification
The bench builds the block with short lines and frames: 40 and 48 clocks per line, 12 and 15 lines per frame, active windows starting at counts 8 and 10, and second-field windows on lines 7 and 8. With these values a whole frame wrap, the field-flag flywheel, both wrap points and the acceptance window for the second-field sync can all be reached in a few hundred clocks. The sync delays keep their full 3-bit range, so the bench can test non-zero delays on both syncs against hand-counted edges.

// File: rtl/vtrk_pkg.sv
package vtrk_pkg;

    typedef enum logic [1:0] {
        TAG_CB    = 2'b00,
        TAG_Y     = 2'b01,
        TAG_CR    = 2'b10,
        TAG_BLANK = 2'b11
    } comp_tag_e;

    // Sample kind from the two-bit phase inside the active window
    function automatic comp_tag_e tag_of(input logic [1:0] phase, input logic swap);
        if (phase[0])
            return TAG_Y;
        else if (phase[1] ^ swap)
            return TAG_CR;
        else
            return TAG_CB;
    endfunction

endpackage

// File: rtl/vtrk_sync_delay.sv
module vtrk_sync_delay #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [SEL_W-1:0] sel,
    output logic             sig_out
);
    localparam int DEPTH = (1 << SEL_W) - 1;

    logic [DEPTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[DEPTH-2:0], sig_in};
        if (sel == '0)
            sig_out = sig_in;
        else
            sig_out = sr_q[sel - SEL_W'(1)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '1;
        else
            sr_q <= sr_d;
    end

endmodule

// File: rtl/vtrk_hpos.sv
module vtrk_hpos
    import vtrk_pkg::*;
#(
    parameter int N_LINE_CLKS = 1560,
    parameter int P_LINE_CLKS = 1888,
    parameter int N_CB_START  = 236,
    parameter int P_CB_START  = 310,
    parameter int N_ACT_BYTES = 1280,
    parameter int P_ACT_BYTES = 1536,
    parameter int HW          = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pal_mode,
    input  logic          hs_n,
    input  logic          swap_cbcr,
    output logic [HW-1:0] h_count,
    output logic          line_start,
    output logic          active,
    output comp_tag_e     tag
);
    localparam logic [HW-1:0] N_LAST    = HW'(N_LINE_CLKS - 1);
    localparam logic [HW-1:0] P_LAST    = HW'(P_LINE_CLKS - 1);
    localparam logic [HW-1:0] N_ACT_LO  = HW'(N_CB_START);
    localparam logic [HW-1:0] P_ACT_LO  = HW'(P_CB_START);
    localparam logic [HW-1:0] N_ACT_HI  = HW'(N_CB_START + N_ACT_BYTES - 1);
    localparam logic [HW-1:0] P_ACT_HI  = HW'(P_CB_START + P_ACT_BYTES - 1);

    typedef struct packed {
        logic [HW-1:0] h;
        logic          hs_prev;
        logic          act;
        comp_tag_e     tag;
    } hstate_t;

    hstate_t st_d, st_q;

    logic [HW-1:0] last_cnt, act_lo, act_hi;
    logic          hs_fall, wrap, in_act;
    logic [1:0]    phase;

    always_comb begin
        last_cnt = pal_mode ? P_LAST   : N_LAST;
        act_lo   = pal_mode ? P_ACT_LO : N_ACT_LO;
        act_hi   = pal_mode ? P_ACT_HI : N_ACT_HI;

        hs_fall    = st_q.hs_prev & ~hs_n;
        wrap       = (st_q.h >= last_cnt);
        line_start = hs_fall | wrap;

        st_d         = st_q;
        st_d.hs_prev = hs_n;
        st_d.h       = line_start ? '0 : st_q.h + HW'(1);

        in_act   = (st_d.h >= act_lo) && (st_d.h <= act_hi);
        phase    = st_d.h[1:0] - act_lo[1:0];
        st_d.act = in_act;
        st_d.tag = in_act ? tag_of(phase, swap_cbcr) : TAG_BLANK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.h       <= '0;
            st_q.hs_prev <= 1'b1;
            st_q.act     <= 1'b0;
            st_q.tag     <= TAG_BLANK;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_count = st_q.h;
    assign active  = st_q.act;
    assign tag     = st_q.tag;

    AST_FALL_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hs_fall |=> (h_count == '0)); // R1
    AST_FLYWHEEL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fall && h_count == last_cnt) |=> (h_count == '0)); // R2
    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fall && h_count < last_cnt) |=> (h_count == $past(h_count) + HW'(1))); // R2

endmodule

// File: rtl/vtrk_vpos.sv
module vtrk_vpos #(
    parameter int N_FRAME_LINES = 525,
    parameter int P_FRAME_LINES = 625,
    parameter int N_ODD_LINE    = 4,
    parameter int P_ODD_LINE    = 1,
    parameter int N_EVEN_LINE   = 266,
    parameter int P_EVEN_LINE   = 313,
    parameter int N_EVEN_CLK    = 780,
    parameter int P_EVEN_CLK    = 944,
    parameter int HW            = 11,
    parameter int LW            = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pal_mode,
    input  logic [HW-1:0] h_count,
    input  logic          line_start,
    input  logic          hs_n,
    input  logic          vs_n,
    output logic [LW-1:0] line_num,
    output logic          even_field,
    output logic          frame_start
);
    typedef struct packed {
        logic [LW-1:0] line;
        logic          even;
        logic          vs_prev;
        logic          fs;
    } vstate_t;

    vstate_t st_d, st_q;

    logic [LW-1:0] frame_lines, odd_line, even_line, even_next, line_inc;
    logic [HW-1:0] win_from;
    logic          vs_fall, odd_det, in_win, even_acc;

    always_comb begin
        frame_lines = pal_mode ? LW'(P_FRAME_LINES)   : LW'(N_FRAME_LINES);
        odd_line    = pal_mode ? LW'(P_ODD_LINE)      : LW'(N_ODD_LINE);
        even_line   = pal_mode ? LW'(P_EVEN_LINE)     : LW'(N_EVEN_LINE);
        even_next   = pal_mode ? LW'(P_EVEN_LINE + 1) : LW'(N_EVEN_LINE + 1);
        win_from    = pal_mode ? HW'(P_EVEN_CLK - 1)  : HW'(N_EVEN_CLK - 1);

        vs_fall  = st_q.vs_prev & ~vs_n;
        odd_det  = vs_fall & ~hs_n;
        in_win   = (st_q.line == even_line) && (h_count >= win_from) && !line_start;
        even_acc = vs_fall & hs_n & in_win;
        line_inc = (st_q.line >= frame_lines) ? LW'(1) : st_q.line + LW'(1);

        st_d         = st_q;
        st_d.vs_prev = vs_n;
        st_d.fs      = odd_det;

        if (odd_det) begin
            st_d.line = odd_line;
            st_d.even = 1'b0;
        end else begin
            if (line_start) begin
                st_d.line = line_inc;
                if (line_inc == even_next)
                    st_d.even = 1'b1;
                else if (line_inc == odd_line)
                    st_d.even = 1'b0;
            end
            if (even_acc)
                st_d.even = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.line    <= LW'(1);
            st_q.even    <= 1'b0;
            st_q.vs_prev <= 1'b1;
            st_q.fs      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_num    = st_q.line;
    assign even_field  = st_q.even;
    assign frame_start = st_q.fs;

    AST_ODD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        odd_det |=> (line_num == $past(odd_line) && !even_field)); // R5
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !odd_det && line_num == frame_lines) |=> (line_num == LW'(1))); // R6
    AST_EVEN_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        even_acc |=> even_field); // R7
    AST_EVEN_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_fall && hs_n && !in_win && !line_start) |=> ($stable(line_num) && $stable(even_field))); // R7
    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R12

endmodule

// File: rtl/slave_sync_tracker.sv
module slave_sync_tracker #(
    parameter int N_LINE_CLKS   = 1560,
    parameter int P_LINE_CLKS   = 1888,
    parameter int N_CB_START    = 236,
    parameter int P_CB_START    = 310,
    parameter int N_ACT_BYTES   = 1280,
    parameter int P_ACT_BYTES   = 1536,
    parameter int N_FRAME_LINES = 525,
    parameter int P_FRAME_LINES = 625,
    parameter int N_ODD_LINE    = 4,
    parameter int P_ODD_LINE    = 1,
    parameter int N_EVEN_LINE   = 266,
    parameter int P_EVEN_LINE   = 313,
    parameter int N_EVEN_CLK    = 780,
    parameter int P_EVEN_CLK    = 944,
    parameter int DLY_W         = 3,
    parameter int HW            = $clog2((N_LINE_CLKS > P_LINE_CLKS) ? N_LINE_CLKS : P_LINE_CLKS),
    parameter int LW            = $clog2(((N_FRAME_LINES > P_FRAME_LINES) ? N_FRAME_LINES : P_FRAME_LINES) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pal_mode,
    input  logic             hsync_n,
    input  logic             vsync_n,
    input  logic [DLY_W-1:0] hs_delay,
    input  logic [DLY_W-1:0] vs_delay,
    input  logic             swap_cbcr,
    output logic [HW-1:0]    h_count,
    output logic [LW-1:0]    line_num,
    output logic             even_field,
    output logic             active,
    output logic [1:0]       comp_tag,
    output logic             frame_start
);
    import vtrk_pkg::*;

    logic      hs_dly_n, vs_dly_n, line_start;
    comp_tag_e tag;

    vtrk_sync_delay #(.SEL_W(DLY_W)) u_hs_delay (
        .clk(clk), .rst_n(rst_n), .sig_in(hsync_n), .sel(hs_delay), .sig_out(hs_dly_n)
    );

    vtrk_sync_delay #(.SEL_W(DLY_W)) u_vs_delay (
        .clk(clk), .rst_n(rst_n), .sig_in(vsync_n), .sel(vs_delay), .sig_out(vs_dly_n)
    );

    vtrk_hpos #(
        .N_LINE_CLKS(N_LINE_CLKS), .P_LINE_CLKS(P_LINE_CLKS),
        .N_CB_START(N_CB_START),   .P_CB_START(P_CB_START),
        .N_ACT_BYTES(N_ACT_BYTES), .P_ACT_BYTES(P_ACT_BYTES),
        .HW(HW)
    ) u_hpos (
        .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .hs_n(hs_dly_n),
        .swap_cbcr(swap_cbcr), .h_count(h_count), .line_start(line_start),
        .active(active), .tag(tag)
    );

    vtrk_vpos #(
        .N_FRAME_LINES(N_FRAME_LINES), .P_FRAME_LINES(P_FRAME_LINES),
        .N_ODD_LINE(N_ODD_LINE),       .P_ODD_LINE(P_ODD_LINE),
        .N_EVEN_LINE(N_EVEN_LINE),     .P_EVEN_LINE(P_EVEN_LINE),
        .N_EVEN_CLK(N_EVEN_CLK),       .P_EVEN_CLK(P_EVEN_CLK),
        .HW(HW), .LW(LW)
    ) u_vpos (
        .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .h_count(h_count),
        .line_start(line_start), .hs_n(hs_dly_n), .vs_n(vs_dly_n),
        .line_num(line_num), .even_field(even_field), .frame_start(frame_start)
    );

    assign comp_tag = tag;

endmodule

// File: tb/slave_sync_tracker_bench.sv
module slave_sync_tracker_bench;

    localparam int HW = 6;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pal_mode = 1'b0;
    logic          hsync_n = 1'b1;
    logic          vsync_n = 1'b1;
    logic [2:0]    hs_delay = '0;
    logic [2:0]    vs_delay = '0;
    logic          swap_cbcr = 1'b0;
    logic [HW-1:0] h_count;
    logic [LW-1:0] line_num;
    logic          even_field, active, frame_start;
    logic [1:0]    comp_tag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    slave_sync_tracker #(
        .N_LINE_CLKS(40),   .P_LINE_CLKS(48),
        .N_CB_START(8),     .P_CB_START(10),
        .N_ACT_BYTES(16),   .P_ACT_BYTES(24),
        .N_FRAME_LINES(12), .P_FRAME_LINES(15),
        .N_ODD_LINE(4),     .P_ODD_LINE(1),
        .N_EVEN_LINE(7),    .P_EVEN_LINE(8),
        .N_EVEN_CLK(20),    .P_EVEN_CLK(24),
        .DLY_W(3), .HW(HW), .LW(LW)
    ) u_slave_sync_tracker (
        .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .hs_delay(hs_delay), .vs_delay(vs_delay),
        .swap_cbcr(swap_cbcr), .h_count(h_count), .line_num(line_num),
        .even_field(even_field), .active(active), .comp_tag(comp_tag),
        .frame_start(frame_start)
    );

    typedef struct packed {
        logic       pal;
        logic       swap;
        logic [5:0] cnt;
        logic       act;
        logic [1:0] tag;
    } vec_t;

    // Bench active windows: 8..23 (mode 0), 10..33 (mode 1)
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 6'd7,  1'b0, 2'b11},
        '{1'b0, 1'b0, 6'd8,  1'b1, 2'b00},
        '{1'b0, 1'b0, 6'd9,  1'b1, 2'b01},
        '{1'b0, 1'b0, 6'd10, 1'b1, 2'b10},
        '{1'b0, 1'b0, 6'd23, 1'b1, 2'b01},
        '{1'b0, 1'b0, 6'd24, 1'b0, 2'b11},
        '{1'b0, 1'b1, 6'd8,  1'b1, 2'b10},
        '{1'b0, 1'b1, 6'd14, 1'b1, 2'b00},
        '{1'b1, 1'b0, 6'd9,  1'b0, 2'b11},
        '{1'b1, 1'b0, 6'd10, 1'b1, 2'b00},
        '{1'b1, 1'b0, 6'd33, 1'b1, 2'b01},
        '{1'b1, 1'b0, 6'd34, 1'b0, 2'b11},
        '{1'b1, 1'b1, 6'd12, 1'b1, 2'b00},
        '{1'b1, 1'b0, 6'd47, 1'b0, 2'b11}
    };

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic pal, input logic swap, input int hd, input int vd);
        rst_n     = 1'b0;
        hsync_n   = 1'b1;
        vsync_n   = 1'b1;
        pal_mode  = pal;
        swap_cbcr = swap;
        hs_delay  = 3'(hd);
        vs_delay  = 3'(vd);
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R13 watchdog: got %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        // R13 reset state
        do_reset(1'b0, 1'b0, 0, 0);
        chk("R13", "h_count", int'(h_count), 0);
        chk("R13", "line_num", int'(line_num), 1);
        chk("R13", "even_field", int'(even_field), 0);
        chk("R13", "active", int'(active), 0);
        chk("R13", "comp_tag", int'(comp_tag), 3);
        chk("R13", "frame_start", int'(frame_start), 0);

        // Table: R1 line alignment, R3 window and order, R4 swap
        for (int v = 0; v < NV; v++) begin
            do_reset(VECS[v].pal, VECS[v].swap, 0, 0);
            tick(2);
            hsync_n = 1'b0;
            tick(1);
            chk("R1", "h_count at fall", int'(h_count), 0);
            hsync_n = 1'b1;
            tick(int'(VECS[v].cnt));
            chk("R1", "h_count", int'(h_count), int'(VECS[v].cnt));
            chk("R3", "active", int'(active), int'(VECS[v].act));
            chk(VECS[v].swap ? "R4" : "R3", "comp_tag", int'(comp_tag), int'(VECS[v].tag));
        end

        // R2 / R6 flywheel wrap, mode 0
        do_reset(1'b0, 1'b0, 0, 0);
        tick(39);
        chk("R2", "h_count last", int'(h_count), 39);
        chk("R6", "line before wrap", int'(line_num), 1);
        tick(1);
        chk("R2", "h_count wrap", int'(h_count), 0);
        chk("R6", "line after wrap", int'(line_num), 2);

        // R2 wrap, mode 1
        do_reset(1'b1, 1'b0, 0, 0);
        tick(47);
        chk("R2", "h_count last mode1", int'(h_count), 47);
        tick(1);
        chk("R2", "h_count wrap mode1", int'(h_count), 0);

        // R11 out-of-place horizontal sync
        do_reset(1'b0, 1'b0, 0, 0);
        tick(10);
        hsync_n = 1'b0;
        tick(1);
        chk("R11", "h_count resync", int'(h_count), 0);
        chk("R11", "line resync", int'(line_num), 2);
        hsync_n = 1'b1;
        tick(5);
        chk("R11", "h_count after resync", int'(h_count), 5);

        // R5 / R12 / R8 / R6 first field and field flywheel, mode 0
        do_reset(1'b0, 1'b0, 0, 0);
        tick(3);
        hsync_n = 1'b0;
        vsync_n = 1'b0;
        tick(1);
        chk("R5", "line odd", int'(line_num), 4);
        chk("R5", "even_field odd", int'(even_field), 0);
        chk("R12", "frame_start high", int'(frame_start), 1);
        hsync_n = 1'b1;
        vsync_n = 1'b1;
        tick(1);
        chk("R12", "frame_start low", int'(frame_start), 0);
        tick(158);
        chk("R8", "line 7", int'(line_num), 7);
        chk("R8", "even before", int'(even_field), 0);
        tick(1);
        chk("R8", "line 8", int'(line_num), 8);
        chk("R8", "even set", int'(even_field), 1);
        tick(160);
        chk("R6", "line last", int'(line_num), 12);
        tick(40);
        chk("R6", "line wrap", int'(line_num), 1);
        chk("R8", "even kept", int'(even_field), 1);
        tick(120);
        chk("R8", "line odd again", int'(line_num), 4);
        chk("R8", "even cleared", int'(even_field), 0);

        // R7 accepted second-field sync
        do_reset(1'b0, 1'b0, 0, 0);
        tick(3);
        hsync_n = 1'b0;
        vsync_n = 1'b0;
        tick(1);
        hsync_n = 1'b1;
        vsync_n = 1'b1;
        tick(139);
        chk("R7", "h_count before", int'(h_count), 19);
        vsync_n = 1'b0;
        tick(1);
        chk("R7", "even accepted", int'(even_field), 1);
        chk("R7", "line kept", int'(line_num), 7);
        vsync_n = 1'b1;

        // R7 rejected second-field sync (too early)
        do_reset(1'b0, 1'b0, 0, 0);
        tick(3);
        hsync_n = 1'b0;
        vsync_n = 1'b0;
        tick(1);
        hsync_n = 1'b1;
        vsync_n = 1'b1;
        tick(130);
        vsync_n = 1'b0;
        tick(1);
        chk("R7", "even rejected", int'(even_field), 0);
        chk("R7", "line unchanged", int'(line_num), 7);
        chk("R7", "h_count", int'(h_count), 11);
        vsync_n = 1'b1;

        // R5 first field in mode 1 with horizontal sync already low
        do_reset(1'b1, 1'b0, 0, 0);
        tick(2);
        hsync_n = 1'b0;
        tick(1);
        chk("R5", "line after fall mode1", int'(line_num), 2);
        tick(1);
        vsync_n = 1'b0;
        tick(1);
        chk("R5", "line odd mode1", int'(line_num), 1);
        chk("R5", "h_count mode1", int'(h_count), 2);
        chk("R12", "frame_start mode1", int'(frame_start), 1);
        hsync_n = 1'b1;
        vsync_n = 1'b1;

        // R9 horizontal sync delay of 3
        do_reset(1'b0, 1'b0, 3, 0);
        tick(10);
        hsync_n = 1'b0;
        tick(3);
        chk("R9", "h_count during delay", int'(h_count), 13);
        tick(1);
        chk("R9", "h_count after delay", int'(h_count), 0);
        hsync_n = 1'b1;

        // R10 vertical sync delay of 2
        do_reset(1'b0, 1'b0, 0, 2);
        hsync_n = 1'b0;
        tick(1);
        chk("R10", "line after hfall", int'(line_num), 2);
        vsync_n = 1'b0;
        tick(2);
        chk("R10", "line during delay", int'(line_num), 2);
        tick(1);
        chk("R10", "line after delay", int'(line_num), 4);
        chk("R10", "frame_start", int'(frame_start), 1);
        hsync_n = 1'b1;
        vsync_n = 1'b1;

        done = 1'b1;
        finish_run();
    end

endmodule